// File: doc/BRIEF.md
# Context Switch Conflict Resolver

This block decides which virtual-processor context runs next in a multithreaded in-order core. Three requests can arrive. The hardware scheduler can order a switch to a named context. The instruction stream can carry a software thread switch to a named context. A return can also come in, and it ends a hardware switch and goes back to the context that was interrupted. Every switch takes effect on the next clock edge. No requester is ever stalled, so switching costs no cycles from any thread's budget.

When a hardware switch and a software switch arrive in the same cycle, the hardware switch wins. The software switch is not lost: its target is written into a return register that belongs to the hardware-selected context. When that context later issues its return, the contents of the return register replace the plain return, and the deferred software switch runs in its place. The return register, the saved origin and the pending-conflict flag are held in banks, one bank per context.

Top module: `ctx_switch_resolver`

## Requirements
- R1: After reset `cur_ctx` is 0, `rr_we` is low, and a return issued in any context is not substituted (`ret_sub` low).
- R2: A hardware request with no software request makes `cur_ctx` equal to `hw_ctx` from the next cycle. `rr_we` stays low in that cycle.
- R3: A software request with no hardware request makes `cur_ctx` equal to `sw_ctx` from the next cycle. `rr_we` stays low in that cycle.
- R4: When a hardware request and a software request coincide, `cur_ctx` becomes `hw_ctx` in the next cycle. In the same cycle `rr_we` is high, `rr_idx` equals `hw_ctx` and `rr_ctx` equals `sw_ctx`.
- R5: If a return is issued in a context with no pending conflict, the return is plain. `ret_sub` is low, `ret_tgt` is the context that was running when the hardware switch into the current context was issued, and `cur_ctx` becomes that context in the next cycle.
- R6: If a return is issued in a context with a pending conflict, the return is substituted. `ret_sub` is high, `ret_tgt` is the deferred software target, and `cur_ctx` becomes that target in the next cycle. The pending flag is then cleared, so the next return in that context is plain.
- R7: Pending conflicts and saved origins are kept per context. A plain hardware switch nested inside a conflicted one leaves the outer context's deferred switch intact.
- R8: With no request, `cur_ctx` holds its value. Each cycle has exactly one context selected. A run with a hardware-then-software conflict gives the hardware-selected context the same number of cycles as a run where the two switches arrive one after the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware context switch request |
| hw_ctx | input | CW | Target context of the hardware switch |
| sw_req | input | 1 | Software thread switch decoded from the instruction stream |
| sw_ctx | input | CW | Target context of the software switch |
| ret_req | input | 1 | Return that ends a hardware switch, issued in the current context |
| cur_ctx | output | CW | Context selected for execution |
| rr_we | output | 1 | Return-register write strobe (conflict detected) |
| rr_idx | output | CW | Bank of the return register being written |
| rr_ctx | output | CW | Deferred software target written to the return register |
| ret_sub | output | 1 | The return this cycle is replaced by the return register |
| ret_tgt | output | CW | Context the current return goes to, valid with `ret_req` |

## Verification
The checks assume that a return is issued only in a context that was entered through a hardware switch. They also assume that a return never shares a cycle with a hardware or a software request, because the return and the software switch both come from the single decoded instruction, and the hardware scheduler does not preempt in a cycle when a return is retiring. The directed tasks keep to this rule: each return is sent alone, and only after the matching hardware switch. Only the context indices 0 to NCTX-1 are driven.

// File: rtl/ctx_switch_resolver.sv
module ctx_switch_resolver #(
  parameter int NCTX = 4,
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_req,
  input  logic [CW-1:0] hw_ctx,
  input  logic          sw_req,
  input  logic [CW-1:0] sw_ctx,
  input  logic          ret_req,
  output logic [CW-1:0] cur_ctx,
  output logic          rr_we,
  output logic [CW-1:0] rr_idx,
  output logic [CW-1:0] rr_ctx,
  output logic          ret_sub,
  output logic [CW-1:0] ret_tgt
);

  logic [CW-1:0]   cur_q;
  logic [CW-1:0]   origin_q [NCTX];
  logic [CW-1:0]   rr_q     [NCTX];
  logic [NCTX-1:0] pend_q;
  logic [CW-1:0]   nxt;

  assign cur_ctx = cur_q;
  assign rr_we   = hw_req & sw_req;
  assign rr_idx  = hw_ctx;
  assign rr_ctx  = sw_ctx;
  assign ret_sub = ret_req & pend_q[cur_q];
  assign ret_tgt = pend_q[cur_q] ? rr_q[cur_q] : origin_q[cur_q];

  always_comb begin
    if (hw_req)       nxt = hw_ctx;
    else if (sw_req)  nxt = sw_ctx;
    else if (ret_req) nxt = ret_tgt;
    else              nxt = cur_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < NCTX; i++) begin
        origin_q[i] <= '0;
        rr_q[i]     <= '0;
      end
    end else begin
      cur_q <= nxt;
      if (hw_req) begin
        origin_q[hw_ctx] <= cur_q;
        pend_q[hw_ctx]   <= sw_req;
        if (sw_req) rr_q[hw_ctx] <= sw_ctx;
      end else if (ret_sub) begin
        pend_q[cur_q] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ctx_switch_resolver_chk.sv
module ctx_switch_resolver_chk #(
  parameter int NCTX = 4,
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_req,
  input logic [CW-1:0] hw_ctx,
  input logic          sw_req,
  input logic [CW-1:0] sw_ctx,
  input logic          ret_req,
  input logic [CW-1:0] cur_ctx,
  input logic          rr_we,
  input logic [CW-1:0] rr_idx,
  input logic [CW-1:0] rr_ctx,
  input logic          ret_sub,
  input logic [CW-1:0] ret_tgt
);

  // R2
  hw_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_req |=> cur_ctx == $past(hw_ctx));

  // R3
  sw_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !hw_req) |=> cur_ctx == $past(sw_ctx));

  // R4
  conflict_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && sw_req) |-> (rr_we && rr_idx == hw_ctx && rr_ctx == sw_ctx));

  // R4
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_we |-> (hw_req && sw_req));

  // R5
  return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !hw_req && !sw_req) |=> cur_ctx == $past(ret_tgt));

  // R6
  sub_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_sub && !hw_req) ##1 (ret_req && !hw_req && !sw_req &&
      cur_ctx == $past(cur_ctx)) |-> !ret_sub);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_req && !sw_req && !ret_req) |=> $stable(cur_ctx));

endmodule

bind ctx_switch_resolver ctx_switch_resolver_chk #(.NCTX(NCTX)) chk_i (.*);

// File: tb/ctx_switch_resolver_test.sv
module ctx_switch_resolver_test;
  localparam int NCTX = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_req = 1'b0, sw_req = 1'b0, ret_req = 1'b0;
  logic [CW-1:0] hw_ctx = '0, sw_ctx = '0;
  logic [CW-1:0] cur_ctx, rr_idx, rr_ctx, ret_tgt;
  logic rr_we, ret_sub;

  int checks = 0, errors = 0;
  int cnt [NCTX];
  int steps = 0;
  logic s_we, s_sub;
  logic [CW-1:0] s_idx, s_rctx, s_tgt;

  always #10 clk = ~clk;

  ctx_switch_resolver #(.NCTX(NCTX)) uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_ctx(hw_ctx),
    .sw_req(sw_req), .sw_ctx(sw_ctx), .ret_req(ret_req),
    .cur_ctx(cur_ctx), .rr_we(rr_we), .rr_idx(rr_idx), .rr_ctx(rr_ctx),
    .ret_sub(ret_sub), .ret_tgt(ret_tgt));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit h, int hc, bit s, int sc, bit r);
    cnt[cur_ctx]++;
    steps++;
    hw_req = h; hw_ctx = hc[CW-1:0];
    sw_req = s; sw_ctx = sc[CW-1:0];
    ret_req = r;
    #5;
    s_we = rr_we; s_sub = ret_sub; s_idx = rr_idx; s_rctx = rr_ctx; s_tgt = ret_tgt;
    @(negedge clk);
    hw_req = 0; sw_req = 0; ret_req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    foreach (cnt[i]) cnt[i] = 0;
    steps = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cur_ctx", cur_ctx, 0);
    check("R1 rr_we", rr_we, 0);
    step(1, 2, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    check("R1 ret_sub after reset", s_sub, 0);
  endtask

  task automatic t_hw();
    do_reset();
    step(1, 3, 0, 0, 0);
    check("R2 rr_we", s_we, 0);
    check("R2 cur_ctx", cur_ctx, 3);
    idle(2);
    check("R8 hold", cur_ctx, 3);
  endtask

  task automatic t_sw();
    do_reset();
    step(0, 0, 1, 2, 0);
    check("R3 rr_we", s_we, 0);
    check("R3 cur_ctx", cur_ctx, 2);
  endtask

  task automatic t_conflict_and_return();
    do_reset();
    step(1, 1, 1, 3, 0);
    check("R4 rr_we", s_we, 1);
    check("R4 rr_idx", s_idx, 1);
    check("R4 rr_ctx", s_rctx, 3);
    check("R4 cur_ctx", cur_ctx, 1);
    idle(1);
    step(0, 0, 0, 0, 1);
    check("R6 ret_sub", s_sub, 1);
    check("R6 ret_tgt", s_tgt, 3);
    check("R6 cur_ctx", cur_ctx, 3);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    check("R6 flag cleared", s_sub, 0);
    check("R5 plain return cur_ctx", cur_ctx, 3);
  endtask

  task automatic t_plain_return();
    do_reset();
    step(0, 0, 1, 2, 0);
    step(1, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 0, 0, 1);
    check("R5 ret_sub", s_sub, 0);
    check("R5 ret_tgt", s_tgt, 2);
    check("R5 cur_ctx", cur_ctx, 2);
  endtask

  task automatic t_nested();
    do_reset();
    step(1, 1, 1, 3, 0);
    step(1, 2, 0, 0, 0);
    check("R7 nested cur_ctx", cur_ctx, 2);
    step(0, 0, 0, 0, 1);
    check("R7 inner ret_sub", s_sub, 0);
    check("R7 inner cur_ctx", cur_ctx, 1);
    step(0, 0, 0, 0, 1);
    check("R7 outer ret_sub", s_sub, 1);
    check("R7 outer cur_ctx", cur_ctx, 3);
  endtask

  task automatic t_budget();
    int a1, b1;
    do_reset();
    idle(2); step(1, 1, 1, 2, 0); idle(3); step(0, 0, 0, 0, 1); idle(4);
    a1 = cnt[1];
    check("R8 conflict run total", cnt[0] + cnt[1] + cnt[2] + cnt[3], steps);
    check("R8 conflict run end ctx", cur_ctx, 2);
    do_reset();
    idle(2); step(1, 1, 0, 0, 0); idle(3); step(0, 0, 0, 0, 1);
    step(0, 0, 1, 2, 0); idle(4);
    b1 = cnt[1];
    check("R8 serial run total", cnt[0] + cnt[1] + cnt[2] + cnt[3], steps);
    check("R8 equal budget ctx1", a1, b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hw();
    t_sw();
    t_conflict_and_return();
    t_plain_return();
    t_nested();
    t_budget();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule